// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits behind a CPU-visible configuration window. It turns each window access into a PCI type-0 configuration request for a downstream bus model. The 16-bit window offset supplies the low half of a 32-bit combined address. The low 16 bits of a mapping value supply the upper half. The one-hot device-select field, combined bits [31:11], is reduced to a device number by finding its lowest set bit. The block then packs that number with the bus number, the function bits and the dword-aligned register offset into an enabled configuration address.

Byte, halfword and word reads and writes are accepted. A request is launched one cycle after an accepted access. Read data comes back two cycles after the access. Accesses are refused in three cases: the mapping value asks for type-1 forwarding, the device-select field is empty, or the access is misaligned. A refused access launches nothing, and refused reads return all ones sized to the access. Every accepted access clears the two received-abort flags of the bridge status word.

Top module: `cfgx_top`

## Requirements
- R1: The combined address is {mapCfg[15:0], reqOffset[15:0]}. The device number is the index, counted from 0, of the lowest set bit of combined bits [31:11].
- R2: An accepted access drives cfgReqValid high for one cycle, starting the cycle after it is sampled. The address fields are: bit 31 = 1, bits [30:24] = 0, [23:16] = busNum, [15:11] = device number, [10:8] = reqOffset[10:8], [7:2] = reqOffset[7:2], [1:0] = 0. At the same time cfgReqByteOff = reqOffset[1:0], and cfgReqWrite, cfgReqSize and cfgReqWdata carry the access's values.
- R3: When mapCfg[16] = 1 (type-1 requested), the access launches no request and raises no error. A read returns rspData of 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for sizes byte, halfword and word.
- R4: An access whose device-select field (combined [31:11]) is zero raises errPulse for one cycle, the cycle after it is sampled, and launches no request.
- R5: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A halfword with reqOffset[0] = 1, a word with reqOffset[1:0] != 0, or a reserved size is an error that behaves as in R4. Error reads return sized ones as in R3, with reserved treated as word.
- R6: For every read, rspValid is high for one cycle, two cycles after the access is sampled. An accepted read returns the cfgRspData present while its request is driven. Writes never raise rspValid.
- R7: statusWord bit 13 (received master abort) and bit 12 (received target abort) are set by setMAbort and setTAbort. Both are cleared by an accepted access at the edge that launches its request, and a set on that same edge wins. Refused accesses leave both bits alone. All other status bits read 0.
- R8: After reset, cfgReqValid, errPulse and rspValid are low and statusWord is 0.
- R9: The type-1 check comes before the error checks. A type-1 access with an empty device-select field, or with a misaligned offset, raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Window access present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqOffset | input | 16 | Low 16 bits of the window offset |
| reqWdata | input | 32 | Write data |
| mapCfg | input | 17 | [15:0] upper combined address half, [16] type-1 request |
| busNum | input | 8 | Static bus number placed in the output address |
| setMAbort | input | 1 | Sets the received-master-abort status flag |
| setTAbort | input | 1 | Sets the received-target-abort status flag |
| cfgRspData | input | 32 | Read data from the downstream model while a request is driven |
| cfgReqValid | output | 1 | Configuration request strobe |
| cfgReqWrite | output | 1 | Request direction |
| cfgReqSize | output | 2 | Request size |
| cfgReqAddr | output | 32 | Enabled type-0 configuration address |
| cfgReqByteOff | output | 2 | Byte lane within the addressed dword |
| cfgReqWdata | output | 32 | Request write data |
| errPulse | output | 1 | One-cycle error for an empty select field or misalignment |
| rspValid | output | 1 | Read result strobe |
| rspData | output | 32 | Read result |
| statusWord | output | 16 | Bridge status word holding the two abort flags |

## Verification
The select field is driven with one bit taken from the offset alone, with one bit taken from the mapping half alone, and with several bits set at once. These cases separate a lowest-bit decode from a highest-bit decode or a decode of the wrong field. Every size is tried at every byte offset, which shows the alignment rules apart from the byte-lane pass-through. Type-1 accesses are paired with empty and misaligned offsets to expose check ordering. Abort-flag pulses land before, on and after accepted accesses to pin down clear-versus-set priority. A long pseudo-random stream then mixes all of these back to back against the cycle model.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int OFS_W       = 16;
  localparam int MAPH_W      = 16;
  localparam int CMB_W       = OFS_W + MAPH_W;
  localparam int IDSEL_LO    = 11;
  localparam int IDSEL_W     = CMB_W - IDSEL_LO;
  localparam int DEV_W       = $clog2(IDSEL_W);
  localparam int BUS_W       = 8;
  localparam int DATA_W      = 32;
  localparam int STAT_W      = 16;
  localparam int STAT_TABORT = 12;
  localparam int STAT_MABORT = 13;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xferSize_e;

  typedef struct packed {
    logic launch;
    logic clrAbort;
    logic capRsp;
    logic fillOnes;
  } dpStrobe_t;
endpackage

// File: rtl/cfgx_lsb_enc.sv
module cfgx_lsb_enc #(
  parameter int IN_W  = 21,
  parameter int IDX_W = 5
) (
  input  logic [IN_W-1:0]  vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  always_comb begin
    idx = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    none = ~|vec;
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqOfsLow,
  input  logic      type1Req,
  input  logic      idselZero,
  output dpStrobe_t strb,
  output logic      cfgReqValid,
  output logic      errPulse,
  output logic      rspValid
);
  logic misAligned, acceptNow, badNow, refuseNow;
  logic rdAccQ, rdOnesQ;
  xferSize_e sizeE;

  assign sizeE = xferSize_e'(reqSize);

  always_comb begin
    unique case (sizeE)
      SZ_BYTE: misAligned = 1'b0;
      SZ_HALF: misAligned = reqOfsLow[0];
      SZ_WORD: misAligned = |reqOfsLow;
      default: misAligned = 1'b1;
    endcase
  end

  // type-1 refusal is decided before any error condition
  assign refuseNow = reqValid & type1Req;
  assign badNow    = reqValid & ~type1Req & (misAligned | idselZero);
  assign acceptNow = reqValid & ~type1Req & ~misAligned & ~idselZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReqValid <= 1'b0;
      errPulse    <= 1'b0;
      rdAccQ      <= 1'b0;
      rdOnesQ     <= 1'b0;
      rspValid    <= 1'b0;
    end else begin
      cfgReqValid <= acceptNow;
      errPulse    <= badNow;
      rdAccQ      <= acceptNow & ~reqWrite;
      rdOnesQ     <= (refuseNow | badNow) & ~reqWrite;
      rspValid    <= rdAccQ | rdOnesQ;
    end
  end

  always_comb begin
    strb.launch   = acceptNow;
    strb.clrAbort = acceptNow;
    strb.capRsp   = rdAccQ;
    strb.fillOnes = rdOnesQ;
  end
endmodule

// File: rtl/cfgx_dp.sv
module cfgx_dp
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFS_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [MAPH_W-1:0] mapHigh,
  input  logic [BUS_W-1:0]  busNum,
  input  logic [DATA_W-1:0] cfgRspData,
  input  logic              setMAbort,
  input  logic              setTAbort,
  output logic              idselZero,
  output logic [31:0]       cfgReqAddr,
  output logic              cfgReqWrite,
  output logic [1:0]        cfgReqSize,
  output logic [1:0]        cfgReqByteOff,
  output logic [DATA_W-1:0] cfgReqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic [STAT_W-1:0] statusWord
);
  logic [CMB_W-1:0]   combined;
  logic [DEV_W-1:0]   devNum;
  logic [31:0]        nextAddr;
  logic [1:0]         sizeAnyQ;
  logic               mAbortQ, tAbortQ;
  logic [DATA_W-1:0]  onesVal;

  assign combined = {mapHigh, reqOffset};

  cfgx_lsb_enc #(
    .IN_W (IDSEL_W),
    .IDX_W(DEV_W)
  ) i_enc (
    .vec (combined[CMB_W-1:IDSEL_LO]),
    .idx (devNum),
    .none(idselZero)
  );

  assign nextAddr = {1'b1, 7'd0, busNum, devNum, combined[10:2], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReqAddr    <= '0;
      cfgReqWrite   <= 1'b0;
      cfgReqSize    <= '0;
      cfgReqByteOff <= '0;
      cfgReqWdata   <= '0;
    end else if (strb.launch) begin
      cfgReqAddr    <= nextAddr;
      cfgReqWrite   <= reqWrite;
      cfgReqSize    <= reqSize;
      cfgReqByteOff <= reqOffset[1:0];
      cfgReqWdata   <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sizeAnyQ <= '0;
    else if (reqValid) sizeAnyQ <= reqSize;
  end

  always_comb begin
    unique case (xferSize_e'(sizeAnyQ))
      SZ_BYTE: onesVal = DATA_W'(8'hFF);
      SZ_HALF: onesVal = DATA_W'(16'hFFFF);
      default: onesVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspData <= '0;
    else if (strb.capRsp) rspData <= cfgRspData;
    else if (strb.fillOnes) rspData <= onesVal;
  end

  // a new abort event on the clearing edge is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAbortQ <= 1'b0;
      tAbortQ <= 1'b0;
    end else begin
      mAbortQ <= setMAbort | (mAbortQ & ~strb.clrAbort);
      tAbortQ <= setTAbort | (tAbortQ & ~strb.clrAbort);
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[STAT_MABORT] = mAbortQ;
    statusWord[STAT_TABORT] = tAbortQ;
  end
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [15:0] reqOffset,
  input  logic [31:0] reqWdata,
  input  logic [16:0] mapCfg,
  input  logic [7:0]  busNum,
  input  logic        setMAbort,
  input  logic        setTAbort,
  input  logic [31:0] cfgRspData,
  output logic        cfgReqValid,
  output logic        cfgReqWrite,
  output logic [1:0]  cfgReqSize,
  output logic [31:0] cfgReqAddr,
  output logic [1:0]  cfgReqByteOff,
  output logic [31:0] cfgReqWdata,
  output logic        errPulse,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic [15:0] statusWord
);
  dpStrobe_t strb;
  logic      idselZero;

  cfgx_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqOfsLow  (reqOffset[1:0]),
    .type1Req   (mapCfg[16]),
    .idselZero  (idselZero),
    .strb       (strb),
    .cfgReqValid(cfgReqValid),
    .errPulse   (errPulse),
    .rspValid   (rspValid)
  );

  cfgx_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .reqOffset    (reqOffset),
    .reqWdata     (reqWdata),
    .mapHigh      (mapCfg[15:0]),
    .busNum       (busNum),
    .cfgRspData   (cfgRspData),
    .setMAbort    (setMAbort),
    .setTAbort    (setTAbort),
    .idselZero    (idselZero),
    .cfgReqAddr   (cfgReqAddr),
    .cfgReqWrite  (cfgReqWrite),
    .cfgReqSize   (cfgReqSize),
    .cfgReqByteOff(cfgReqByteOff),
    .cfgReqWdata  (cfgReqWdata),
    .rspData      (rspData),
    .statusWord   (statusWord)
  );
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqSize,
  input logic [15:0] reqOffset,
  input logic [31:0] reqWdata,
  input logic [16:0] mapCfg,
  input logic [7:0]  busNum,
  input logic        setMAbort,
  input logic        setTAbort,
  input logic [31:0] cfgRspData,
  input logic        cfgReqValid,
  input logic        cfgReqWrite,
  input logic [1:0]  cfgReqSize,
  input logic [31:0] cfgReqAddr,
  input logic [1:0]  cfgReqByteOff,
  input logic [31:0] cfgReqWdata,
  input logic        errPulse,
  input logic        rspValid,
  input logic [31:0] rspData,
  input logic [15:0] statusWord
);
  // R2
  req_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> cfgReqAddr[31] && cfgReqAddr[30:24] == 7'd0 &&
                    cfgReqAddr[1:0] == 2'd0 && cfgReqAddr[23:16] == $past(busNum));

  // R3
  type1_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> $past(reqValid) && !$past(mapCfg[16]));

  // R3
  type1_byte_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(mapCfg[16], 2) && $past(reqSize, 2) == 2'd0 |-> rspData == 32'h0000_00FF);

  // R4
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !cfgReqValid && $past(reqValid));

  // R5
  half_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && cfgReqSize == 2'd1 |-> !cfgReqByteOff[0]);

  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && cfgReqSize == 2'd2 |-> cfgReqByteOff == 2'd0);

  // R6
  rsp_from_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid, 2) && !$past(reqWrite, 2));

  // R7
  mabort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && !$past(setMAbort) |-> !statusWord[13]);

  // R9
  type1_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && $past(mapCfg[16]) |-> !errPulse);
endmodule

bind cfgx_top cfgx_chk i_chk (.*);

// File: tb/test_cfgx_top.sv
module test_cfgx_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [15:0] reqOffset = 16'd0;
  logic [31:0] reqWdata = 32'd0;
  logic [16:0] mapCfg = 17'd0;
  logic [7:0]  busNum = 8'h3C;
  logic        setMAbort = 1'b0, setTAbort = 1'b0;
  logic [31:0] cfgRspData;
  logic        cfgReqValid, cfgReqWrite, errPulse, rspValid;
  logic [1:0]  cfgReqSize, cfgReqByteOff;
  logic [31:0] cfgReqAddr, cfgReqWdata, rspData;
  logic [15:0] statusWord;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  function automatic logic [31:0] rspOf(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  assign cfgRspData = rspOf(cfgReqAddr);

  cfgx_top i_cfgx_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqOffset(reqOffset), .reqWdata(reqWdata),
    .mapCfg(mapCfg), .busNum(busNum), .setMAbort(setMAbort),
    .setTAbort(setTAbort), .cfgRspData(cfgRspData),
    .cfgReqValid(cfgReqValid), .cfgReqWrite(cfgReqWrite),
    .cfgReqSize(cfgReqSize), .cfgReqAddr(cfgReqAddr),
    .cfgReqByteOff(cfgReqByteOff), .cfgReqWdata(cfgReqWdata),
    .errPulse(errPulse), .rspValid(rspValid), .rspData(rspData),
    .statusWord(statusWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference
  logic        eReqV, eReqW, eErr, eRdAcc, eRdOnes, eRspV;
  logic [1:0]  eSize, eByte, eOnesSize;
  logic [31:0] eAddr, eWdata, eRspData;
  logic [15:0] eStat;
  string       eErrTag, eRspTag, pendTag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eReqV = 0; eReqW = 0; eErr = 0; eRdAcc = 0; eRdOnes = 0; eRspV = 0;
      eSize = 0; eByte = 0; eOnesSize = 0; eAddr = 0; eWdata = 0;
      eRspData = 0; eStat = 0; eErrTag = "R4"; eRspTag = "R6"; pendTag = "R6";
    end else begin
      logic [31:0] cmb;
      int          dev;
      bit          t1, mis, acc, bad, none;
      eRspV = eRdAcc | eRdOnes;
      eRspTag = pendTag;
      if (eRdAcc) eRspData = rspOf(eAddr);
      else if (eRdOnes) eRspData = (eOnesSize == 0) ? 32'hFF :
                                   (eOnesSize == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      cmb = {mapCfg[15:0], reqOffset};
      t1 = mapCfg[16];
      dev = -1;
      for (int i = 11; i < 32; i++) if (dev < 0 && cmb[i]) dev = i - 11;
      none = (dev < 0);
      case (reqSize)
        2'd0: mis = 0;
        2'd1: mis = reqOffset[0];
        2'd2: mis = (reqOffset[1:0] != 0);
        default: mis = 1;
      endcase
      acc = reqValid && !t1 && !mis && !none;
      bad = reqValid && !t1 && (mis || none);
      eReqV = acc;
      if (acc) begin
        eAddr = 32'h8000_0000 | (32'(busNum) << 16) | (32'(dev) << 11) |
                (32'(reqOffset[10:8]) << 8) | 32'(reqOffset[7:2] << 2);
        eReqW = reqWrite; eSize = reqSize; eByte = reqOffset[1:0]; eWdata = reqWdata;
      end
      eErr = bad;
      eErrTag = bad ? (mis ? "R5" : "R4") : ((reqValid && t1) ? "R9" : "R4");
      eRdAcc = acc && !reqWrite;
      eRdOnes = (bad || (reqValid && t1)) && !reqWrite;
      pendTag = (reqValid && t1) ? "R3" : (bad ? (mis ? "R5" : "R4") : "R6");
      if (reqValid) eOnesSize = reqSize;
      if (acc) eStat = 0;
      if (setMAbort) eStat[13] = 1;
      if (setTAbort) eStat[12] = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R2 cfgReqValid", 32'(cfgReqValid), 32'(eReqV));
      check({eErrTag, " errPulse"}, 32'(errPulse), 32'(eErr));
      check("R6 rspValid", 32'(rspValid), 32'(eRspV));
      check("R7 statusWord", 32'(statusWord), 32'(eStat));
      if (eReqV) begin
        check("R1 device field", 32'(cfgReqAddr[15:11]), 32'(eAddr[15:11]));
        check("R2 cfgReqAddr", cfgReqAddr, eAddr);
        check("R2 byteOff", 32'(cfgReqByteOff), 32'(eByte));
        check("R2 size", 32'(cfgReqSize), 32'(eSize));
        check("R2 write", 32'(cfgReqWrite), 32'(eReqW));
        check("R2 wdata", cfgReqWdata, eWdata);
      end
      if (eRspV) check({eRspTag, " rspData"}, rspData, eRspData);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic acc(input bit w, input logic [1:0] sz, input logic [15:0] ofs,
                     input logic [16:0] map);
    reqValid = 1; reqWrite = w; reqSize = sz; reqOffset = ofs; mapCfg = map;
    reqWdata = {ofs, 15'd0, w} ^ 32'hC3A5_1E0F;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    reqValid = 0; setMAbort = 0; setTAbort = 0;
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] lfsr = 32'hACE1_2357;

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 cfgReqValid", 32'(cfgReqValid), 0);
    check("R8 errPulse", 32'(errPulse), 0);
    check("R8 rspValid", 32'(rspValid), 0);
    check("R8 statusWord", 32'(statusWord), 0);
    rstN = 1;
    idle(2);
    // R1/R2 select bit from offset, from mapping half, multiple bits
    acc(0, 2'd2, 16'h0800, 17'h0);
    acc(1, 2'd2, 16'h8A04, 17'h0);
    acc(0, 2'd1, 16'h0312, 17'h00002);
    acc(0, 2'd0, 16'h0003, 17'h08000);
    acc(0, 2'd2, 16'hF7FC, 17'h0FFFF);
    idle(3);
    for (int b = 0; b < 4; b++) acc(0, 2'd0, 16'h1000 | 16'(b), 17'h0);
    idle(3);
    // R3 type-1 sizes and write
    acc(0, 2'd0, 16'h0800, 17'h10004);
    acc(0, 2'd1, 16'h0800, 17'h10004);
    acc(0, 2'd2, 16'h0800, 17'h10004);
    acc(1, 2'd2, 16'h0800, 17'h10004);
    idle(3);
    // R4 empty select, R5 misalignment and reserved size
    acc(0, 2'd2, 16'h07FC, 17'h0);
    acc(1, 2'd0, 16'h0000, 17'h0);
    acc(0, 2'd1, 16'h0801, 17'h0);
    acc(0, 2'd2, 16'h0802, 17'h0);
    acc(1, 2'd2, 16'h0801, 17'h0);
    acc(0, 2'd3, 16'h0800, 17'h0);
    idle(3);
    // R9 type-1 beats error checks
    acc(0, 2'd2, 16'h0000, 17'h10000);
    acc(0, 2'd1, 16'h0001, 17'h10000);
    idle(3);
    // R7 status set, refused access keeps, accepted clears, set wins
    setMAbort = 1; setTAbort = 1; @(negedge clk);
    setMAbort = 0; setTAbort = 0;
    acc(0, 2'd2, 16'h0000, 17'h0);
    acc(0, 2'd2, 16'h0000, 17'h10000);
    idle(2);
    acc(0, 2'd2, 16'h2000, 17'h0);
    idle(2);
    setTAbort = 1; acc(1, 2'd2, 16'h2000, 17'h0);
    setTAbort = 0; setMAbort = 1; acc(0, 2'd2, 16'h2000, 17'h0);
    idle(3);
    // mixed stream
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      setMAbort = (lfsr[7:4] == 4'h3);
      setTAbort = (lfsr[11:8] == 4'h5);
      busNum = lfsr[23:16];
      if (lfsr[2]) acc(lfsr[3], lfsr[5:4], lfsr[31:16],
                       {lfsr[12] & lfsr[13], (lfsr[14] ? lfsr[15:0] : 16'h0)});
      else idle(1);
    end
    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule